// File: doc/BRIEF.md
# Micro-coded CPU step engine

The engine executes one step of a micro-coded processor emulator each time it is started. One step runs through fixed phases. It fetches a 62-bit micro-instruction from a program ROM at the current program counter. It forms two 29-bit memory addresses, one per operand slot, and reads both operands over a single RAM port, one after the other. It hands both operands to an external ALU and latches the result and carry-out. It optionally writes to the second slot. It then commits the new architectural state in one edge.

The state is a 16-bit program counter, an 18-bit frame pointer kept 256-aligned, a 10-bit call-stack pointer, a 32-bit accumulator and a carry flag. Each memory address is a 3-bit region code followed by a 10-bit base and a 16-bit index. The region code selects where the base and index come from: the frame, the stack pointer, the accumulator, or zero. The next PC comes from one of four rules: fall through, jump, jump on carry, or jump to the accumulator.

Top module: `ustep_engine`

## Requirements
- R1: A synchronous active-high `rst` clears PC, FP, SP, accumulator and carry to zero and holds `done` low.
- R2: If `start` is sampled high at rising edge k while the engine is idle, `done` is high for exactly one cycle after edge k+5, and the architectural outputs change only at that edge.
- R3: The micro-instruction word has this layout: slot-A index [15:0], slot-B index [31:16], ALU control [46:32], slot-A region [49:47], slot-B region [52:50], write enable [53], write select [54], FP load [55], accumulator mode [57:56], SP mode [59:58], PC mode [61:60]. It is read from the ROM address equal to PC.
- R4: Address = {region, base, index}. Region 0 uses base FP[17:8] and the slot index. Region 1 uses base SP and index 0. Region 2 uses base acc[25:16] and index acc[15:0]. Every other region code uses base 0 and the slot index.
- R5: Slot A is read first, then slot B. The two words go to `alu_a`/`alu_b`. Accumulator mode 1 loads the ALU result, mode 2 loads the slot-A word, and modes 0 and 3 keep the accumulator.
- R6: A RAM write occurs in a step only when write enable is 1. It goes to the slot-B address. Its data is the ALU result when write select is 0, and {31 zeros, ALU carry-out} when write select is 1. With write enable 0, memory is untouched.
- R7: PC mode 0 gives PC+1 (wrapping at 16 bits). Mode 1 gives the slot-A index. Mode 2 gives the slot-A index if the carry flag held at the start of the step is 1, else PC+1. Mode 3 gives acc[15:0].
- R8: SP mode 1 increments SP and mode 2 decrements it, both modulo 1024. Modes 0 and 3 hold SP.
- R9: When FP load is 1, FP becomes {slot-A word[9:0], 8'b0}; otherwise FP holds.
- R10: At the end of every step the carry flag takes the ALU carry-out of that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one step (sampled while idle) |
| done | output | 1 | One-cycle pulse when the step has committed |
| rom_addr | output | 16 | Program ROM address (the PC) |
| rom_data | input | 62 | Micro-instruction word at `rom_addr` |
| ram_addr | output | 29 | Unified RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data at `ram_addr` |
| alu_a | output | 32 | Slot-A operand to the ALU |
| alu_b | output | 32 | Slot-B operand to the ALU |
| alu_ctrl | output | 15 | ALU control field of the current micro-instruction |
| alu_result | input | 32 | ALU result |
| alu_carry | input | 1 | ALU carry-out |
| pc_o | output | 16 | Program counter |
| fp_o | output | 18 | Frame pointer |
| sp_o | output | 10 | Call-stack pointer |
| acc_o | output | 32 | Accumulator |
| carry_o | output | 1 | Carry flag |

## Verification
The bench chains steps so that each corner case depends on state left by the step before.

- **Frame reload:** the frame pointer is reloaded and the next step reads a register through the new frame. A wrong frame slice or shift reads the wrong word.
- **Conditional jump:** it is taken on a borrow and not taken on a clear carry. A design that tested the freshly computed carry instead of the one held at the start of the step would take the wrong branch.
- **Wrap-around:** SP is decremented from 0 and incremented back from 1023, and PC falls through from 0xFFFF. An engine that did not wrap at the field width would leave an out-of-range pointer.
- **Accumulator-based addressing and carry write-back:** an accumulator-based address and an indirect jump use separate slices of the same accumulator. A step with write enable clear must leave the write count unchanged. A carry write-back must store exactly 1, not the ALU sum.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int PC_W     = 16;
    localparam int FP_W     = 18;
    localparam int SP_W     = 10;
    localparam int ACC_W    = 32;
    localparam int IDX_W    = 16;
    localparam int BASE_W   = 10;
    localparam int REGION_W = 3;
    localparam int ALU_W    = 15;
    localparam int ADDR_W   = REGION_W + BASE_W + IDX_W;
    localparam int FRAME_LSB = FP_W - BASE_W;

    typedef enum logic [1:0] {PC_NEXT = 2'd0, PC_JUMP = 2'd1, PC_JCARRY = 2'd2, PC_FROM_ACC = 2'd3} pc_mode_e;
    typedef enum logic [1:0] {SP_HOLD = 2'd0, SP_PUSH = 2'd1, SP_POP = 2'd2, SP_HOLD_ALT = 2'd3} sp_mode_e;
    typedef enum logic [1:0] {ACC_HOLD = 2'd0, ACC_FROM_ALU = 2'd1, ACC_FROM_A = 2'd2, ACC_HOLD_ALT = 2'd3} acc_mode_e;
    typedef enum logic [2:0] {
        RG_LOCAL = 3'd0, RG_CALL = 3'd1, RG_HEAP = 3'd2, RG_LIT = 3'd3,
        RG_GLOB  = 3'd4, RG_FTAB = 3'd5, RG_SPARE6 = 3'd6, RG_SPARE7 = 3'd7
    } region_e;

    // Micro-instruction word, most significant field first (R3)
    typedef struct packed {
        pc_mode_e          pc_mode;
        sp_mode_e          sp_mode;
        acc_mode_e         acc_mode;
        logic              fp_load;
        logic              wr_sel;
        logic              wr_en;
        region_e           region_b;
        region_e           region_a;
        logic [ALU_W-1:0]  alu_ctrl;
        logic [IDX_W-1:0]  idx_b;
        logic [IDX_W-1:0]  idx_a;
    } uinstr_t;

    localparam int UINSTR_W = $bits(uinstr_t);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [FP_W-1:0]  fp;
        logic [SP_W-1:0]  sp;
        logic [ACC_W-1:0] acc;
        logic             carry;
    } arch_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0, PH_FETCH = 3'd1, PH_READ_A = 3'd2,
        PH_READ_B = 3'd3, PH_EXEC = 3'd4, PH_WRITE = 3'd5
    } phase_e;

    function automatic logic [ADDR_W-1:0] join_addr(input region_e rg,
                                                    input logic [BASE_W-1:0] base,
                                                    input logic [IDX_W-1:0] idx);
        return {rg, base, idx};
    endfunction

endpackage

// File: rtl/ustep_addr_gen.sv
module ustep_addr_gen
    import ustep_pkg::*;
(
    input  region_e             region,
    input  logic [IDX_W-1:0]    slot_idx,
    input  logic [BASE_W-1:0]   fp_frame,
    input  logic [SP_W-1:0]     sp,
    input  logic [BASE_W-1:0]   acc_base,
    input  logic [IDX_W-1:0]    acc_index,
    output logic [ADDR_W-1:0]   addr
);
    logic [BASE_W-1:0] base;
    logic [IDX_W-1:0]  index;

    // R4: region decides the base and index sources
    always_comb begin
        unique case (region)
            RG_LOCAL: begin base = fp_frame;         index = slot_idx;  end
            RG_CALL:  begin base = BASE_W'(sp);      index = '0;        end
            RG_HEAP:  begin base = acc_base;         index = acc_index; end
            default:  begin base = '0;               index = slot_idx;  end
        endcase
        addr = join_addr(region, base, index);
    end
endmodule

// File: rtl/ustep_next_state.sv
module ustep_next_state
    import ustep_pkg::*;
(
    input  arch_t              cur,
    input  uinstr_t            ui,
    input  logic [ACC_W-1:0]   opa,
    input  logic [ACC_W-1:0]   alu_res,
    input  logic               alu_cy,
    output arch_t              nxt
);
    always_comb begin
        // R7: next program counter
        unique case (ui.pc_mode)
            PC_NEXT:     nxt.pc = cur.pc + PC_W'(1);
            PC_JUMP:     nxt.pc = ui.idx_a;
            PC_JCARRY:   nxt.pc = cur.carry ? ui.idx_a : cur.pc + PC_W'(1);
            PC_FROM_ACC: nxt.pc = cur.acc[PC_W-1:0];
            default:     nxt.pc = cur.pc + PC_W'(1);
        endcase

        // R8: call-stack pointer
        unique case (ui.sp_mode)
            SP_PUSH: nxt.sp = cur.sp + SP_W'(1);
            SP_POP:  nxt.sp = cur.sp - SP_W'(1);
            default: nxt.sp = cur.sp;
        endcase

        // R5: accumulator
        unique case (ui.acc_mode)
            ACC_FROM_ALU: nxt.acc = alu_res;
            ACC_FROM_A:   nxt.acc = opa;
            default:      nxt.acc = cur.acc;
        endcase

        // R9: frame pointer stays 256-aligned
        nxt.fp = ui.fp_load ? {opa[BASE_W-1:0], {FRAME_LSB{1'b0}}} : cur.fp;

        // R10: carry flag
        nxt.carry = alu_cy;
    end
endmodule

// File: rtl/ustep_phase_ctrl.sv
module ustep_phase_ctrl
    import ustep_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   commit,
    output logic   done
);
    phase_e phase_nx;

    always_comb begin
        unique case (phase)
            PH_IDLE:   phase_nx = start ? PH_FETCH : PH_IDLE;
            PH_FETCH:  phase_nx = PH_READ_A;
            PH_READ_A: phase_nx = PH_READ_B;
            PH_READ_B: phase_nx = PH_EXEC;
            PH_EXEC:   phase_nx = PH_WRITE;
            PH_WRITE:  phase_nx = PH_IDLE;
            default:   phase_nx = PH_IDLE;
        endcase
    end

    assign commit = (phase == PH_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= commit;
        end
    end

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> (phase == PH_FETCH));
    a_r2_done_after_write: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE) |=> done);
endmodule

// File: rtl/ustep_engine.sv
module ustep_engine
    import ustep_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output logic                 done,
    output logic [PC_W-1:0]      rom_addr,
    input  logic [UINSTR_W-1:0]  rom_data,
    output logic [ADDR_W-1:0]    ram_addr,
    output logic                 ram_we,
    output logic [ACC_W-1:0]     ram_wdata,
    input  logic [ACC_W-1:0]     ram_rdata,
    output logic [ACC_W-1:0]     alu_a,
    output logic [ACC_W-1:0]     alu_b,
    output logic [ALU_W-1:0]     alu_ctrl,
    input  logic [ACC_W-1:0]     alu_result,
    input  logic                 alu_carry,
    output logic [PC_W-1:0]      pc_o,
    output logic [FP_W-1:0]      fp_o,
    output logic [SP_W-1:0]      sp_o,
    output logic [ACC_W-1:0]     acc_o,
    output logic                 carry_o
);
    localparam int N_SLOTS = 2;

    phase_e           phase;
    logic             commit;
    uinstr_t          instr_q;
    arch_t            arch_q, arch_nx;
    logic [ACC_W-1:0] opa_q, opb_q, res_q;
    logic             cy_q;

    region_e           slot_region [N_SLOTS];
    logic [IDX_W-1:0]  slot_index  [N_SLOTS];
    logic [ADDR_W-1:0] slot_addr   [N_SLOTS];

    ustep_phase_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .phase(phase), .commit(commit), .done(done)
    );

    assign slot_region[0] = instr_q.region_a;
    assign slot_region[1] = instr_q.region_b;
    assign slot_index[0]  = instr_q.idx_a;
    assign slot_index[1]  = instr_q.idx_b;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        ustep_addr_gen u_ag (
            .region   (slot_region[s]),
            .slot_idx (slot_index[s]),
            .fp_frame (arch_q.fp[FP_W-1 -: BASE_W]),
            .sp       (arch_q.sp),
            .acc_base (arch_q.acc[IDX_W +: BASE_W]),
            .acc_index(arch_q.acc[IDX_W-1:0]),
            .addr     (slot_addr[s])
        );
    end

    ustep_next_state u_nxt (
        .cur(arch_q), .ui(instr_q), .opa(opa_q),
        .alu_res(res_q), .alu_cy(cy_q), .nxt(arch_nx)
    );

    // Single RAM port: slot A during its read, slot B from its read to write-back
    always_comb begin
        unique case (phase)
            PH_READ_B, PH_EXEC, PH_WRITE: ram_addr = slot_addr[1];
            default:                      ram_addr = slot_addr[0];
        endcase
    end

    assign ram_we    = commit && instr_q.wr_en;
    assign ram_wdata = instr_q.wr_sel ? {{(ACC_W-1){1'b0}}, cy_q} : res_q;
    assign rom_addr  = arch_q.pc;
    assign alu_a     = opa_q;
    assign alu_b     = opb_q;
    assign alu_ctrl  = instr_q.alu_ctrl;
    assign pc_o      = arch_q.pc;
    assign fp_o      = arch_q.fp;
    assign sp_o      = arch_q.sp;
    assign acc_o     = arch_q.acc;
    assign carry_o   = arch_q.carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            res_q   <= '0;
            cy_q    <= 1'b0;
            arch_q  <= '0;
        end else begin
            unique case (phase)
                PH_FETCH:  instr_q <= uinstr_t'(rom_data);
                PH_READ_A: opa_q   <= ram_rdata;
                PH_READ_B: opb_q   <= ram_rdata;
                PH_EXEC: begin
                    res_q <= alu_result;
                    cy_q  <= alu_carry;
                end
                PH_WRITE:  arch_q  <= arch_nx;
                default: ;
            endcase
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (arch_q == '0 && !done));
    a_r2_state_hold: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_WRITE) |=> $stable(arch_q));
    a_r6_write_same_addr: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $stable(ram_addr));
    a_r7_pc_next: assert property (@(posedge clk) disable iff (rst)
        (commit && instr_q.pc_mode == PC_NEXT) |=> (arch_q.pc == PC_W'($past(arch_q.pc) + 1'b1)));
    a_r8_sp_push: assert property (@(posedge clk) disable iff (rst)
        (commit && instr_q.sp_mode == SP_PUSH) |=> (arch_q.sp == SP_W'($past(arch_q.sp) + 1'b1)));
    a_r10_carry_taken: assert property (@(posedge clk) disable iff (rst)
        commit |=> (arch_q.carry == $past(cy_q)));
endmodule

// File: tb/ustep_engine_test.sv
module ustep_engine_test;
    import ustep_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic done;
    logic [PC_W-1:0] rom_addr;
    logic [UINSTR_W-1:0] rom_data = '0;
    logic [ADDR_W-1:0] ram_addr;
    logic ram_we;
    logic [ACC_W-1:0] ram_wdata, alu_a, alu_b;
    logic [ACC_W-1:0] ram_rdata = '0;
    logic [ACC_W-1:0] alu_result = '0;
    logic alu_carry = 1'b0;
    logic [ALU_W-1:0] alu_ctrl;
    logic [PC_W-1:0] pc_o;
    logic [FP_W-1:0] fp_o;
    logic [SP_W-1:0] sp_o;
    logic [ACC_W-1:0] acc_o;
    logic carry_o;

    always #10 clk = ~clk;   // 50 MHz

    ustep_engine uut (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .alu_a(alu_a), .alu_b(alu_b), .alu_ctrl(alu_ctrl),
        .alu_result(alu_result), .alu_carry(alu_carry),
        .pc_o(pc_o), .fp_o(fp_o), .sp_o(sp_o), .acc_o(acc_o), .carry_o(carry_o)
    );

    // ---------------- memory, ROM and ALU models ----------------
    logic [ACC_W-1:0]    mem [logic [ADDR_W-1:0]];
    logic [UINSTR_W-1:0] rom [logic [PC_W-1:0]];
    int cyc = 0;
    int wcnt = 0;
    logic [ADDR_W-1:0] last_wa = '0;
    logic [ACC_W-1:0]  last_wd = '0;

    function automatic logic [ACC_W-1:0] peek(input logic [ADDR_W-1:0] a);
        if (mem.exists(a)) return mem[a];
        return '0;
    endfunction

    function automatic logic [ACC_W:0] alu_model(input logic [ALU_W-1:0] c,
                                                 input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b);
        if (c[0]) return {1'b0, a} - {1'b0, b};
        return {1'b0, a} + {1'b0, b};
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (ram_we) begin
            mem[ram_addr] = ram_wdata;
            wcnt = wcnt + 1;
            last_wa = ram_addr;
            last_wd = ram_wdata;
        end
    end

    always @(negedge clk) begin
        ram_rdata = peek(ram_addr);
        rom_data  = rom.exists(rom_addr) ? rom[rom_addr] : '0;
        {alu_carry, alu_result} = alu_model(alu_ctrl, alu_a, alu_b);
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        string tag;
        arch_t st;
        logic  wr;
        logic [ADDR_W-1:0] wa;
        logic [ACC_W-1:0]  wd;
        int    wcnt;
        int    c0;
    } exp_t;

    exp_t sb_q[$];
    arch_t m;
    int model_wcnt = 0;
    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4 reference address formation
    function automatic logic [ADDR_W-1:0] ref_addr(input region_e rg, input logic [IDX_W-1:0] idx);
        logic [BASE_W-1:0] b;
        logic [IDX_W-1:0]  i;
        case (rg)
            RG_LOCAL: begin b = m.fp[17:8];   i = idx;          end
            RG_CALL:  begin b = m.sp;         i = '0;           end
            RG_HEAP:  begin b = m.acc[25:16]; i = m.acc[15:0];  end
            default:  begin b = '0;           i = idx;          end
        endcase
        return {rg, b, i};
    endfunction

    // R3 word builder (field layout from the package struct)
    function automatic uinstr_t mk(input pc_mode_e pm, input sp_mode_e sm, input acc_mode_e am,
                                   input logic fpl, input logic ws, input logic we,
                                   input region_e rb, input region_e ra, input logic [ALU_W-1:0] ctl,
                                   input logic [IDX_W-1:0] ib, input logic [IDX_W-1:0] ia);
        uinstr_t u;
        u.pc_mode = pm; u.sp_mode = sm; u.acc_mode = am; u.fp_load = fpl;
        u.wr_sel = ws; u.wr_en = we; u.region_b = rb; u.region_a = ra;
        u.alu_ctrl = ctl; u.idx_b = ib; u.idx_a = ia;
        return u;
    endfunction

    task automatic poke(input region_e rg, input logic [BASE_W-1:0] b,
                        input logic [IDX_W-1:0] i, input logic [ACC_W-1:0] d);
        mem[{rg, b, i}] = d;
    endtask

    task automatic run_step(input uinstr_t u, input string tag);
        exp_t e;
        logic [ADDR_W-1:0] aa, ab;
        logic [ACC_W-1:0] va, vb, res;
        logic cy;
        arch_t n;
        rom[m.pc] = u;
        chk({tag, " R3 rom_addr"}, 64'(rom_addr), 64'(m.pc));
        aa = ref_addr(u.region_a, u.idx_a);
        ab = ref_addr(u.region_b, u.idx_b);
        va = peek(aa);
        vb = peek(ab);
        {cy, res} = alu_model(u.alu_ctrl, va, vb);
        n = m;
        case (u.pc_mode)
            PC_NEXT:   n.pc = m.pc + 16'd1;
            PC_JUMP:   n.pc = u.idx_a;
            PC_JCARRY: n.pc = m.carry ? u.idx_a : m.pc + 16'd1;
            default:   n.pc = m.acc[15:0];
        endcase
        if (u.sp_mode == SP_PUSH) n.sp = m.sp + 10'd1;
        else if (u.sp_mode == SP_POP) n.sp = m.sp - 10'd1;
        if (u.acc_mode == ACC_FROM_ALU) n.acc = res;
        else if (u.acc_mode == ACC_FROM_A) n.acc = va;
        if (u.fp_load) n.fp = {va[9:0], 8'h00};
        n.carry = cy;
        if (u.wr_en) model_wcnt++;
        e.tag = tag; e.st = n; e.wr = u.wr_en; e.wa = ab;
        e.wd = u.wr_sel ? {31'd0, cy} : res;
        e.wcnt = model_wcnt;
        start = 1'b1;
        e.c0 = cyc;
        sb_q.push_back(e);
        m = n;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                chk("R2 stray done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " R2 latency"}, 64'(cyc - e.c0), 64'd6);
                chk({e.tag, " R7 pc"}, 64'(pc_o), 64'(e.st.pc));
                chk({e.tag, " R8 sp"}, 64'(sp_o), 64'(e.st.sp));
                chk({e.tag, " R9 fp"}, 64'(fp_o), 64'(e.st.fp));
                chk({e.tag, " R5 acc"}, 64'(acc_o), 64'(e.st.acc));
                chk({e.tag, " R10 carry"}, 64'(carry_o), 64'(e.st.carry));
                chk({e.tag, " R6 write count"}, 64'(wcnt), 64'(e.wcnt));
                if (e.wr) begin
                    chk({e.tag, " R4 R6 write addr"}, 64'(last_wa), 64'(e.wa));
                    chk({e.tag, " R6 write data"}, 64'(last_wd), 64'(e.wd));
                end
            end
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        m = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pc", 64'(pc_o), 64'd0);
        chk("R1 fp", 64'(fp_o), 64'd0);
        chk("R1 sp", 64'(sp_o), 64'd0);
        chk("R1 acc", 64'(acc_o), 64'd0);
        chk("R1 carry", 64'(carry_o), 64'd0);
        chk("R1 done", 64'(done), 64'd0);

        // S1: frame-local add, result written to slot B, acc from ALU
        poke(RG_LOCAL, 10'd0, 16'd5, 32'd100);
        poke(RG_LOCAL, 10'd0, 16'd6, 32'd23);
        run_step(mk(PC_NEXT, SP_HOLD, ACC_FROM_ALU, 1'b0, 1'b0, 1'b1, RG_LOCAL, RG_LOCAL, 15'd0, 16'd6, 16'd5), "S1 R4 R5");
        // S2: frame reload from a constant, acc from slot A, no write (R6 ignored write)
        poke(RG_LIT, 10'd0, 16'd7, 32'h0000_0003);
        run_step(mk(PC_NEXT, SP_HOLD, ACC_FROM_A, 1'b1, 1'b0, 1'b0, RG_LIT, RG_LIT, 15'd0, 16'd8, 16'd7), "S2 R9 R6");
        // S3: access through new frame, subtract with borrow, carry written, SP push
        poke(RG_LOCAL, 10'd3, 16'd1, 32'd50);
        poke(RG_LOCAL, 10'd3, 16'd2, 32'd80);
        run_step(mk(PC_NEXT, SP_PUSH, ACC_HOLD, 1'b0, 1'b1, 1'b1, RG_LOCAL, RG_LOCAL, 15'd1, 16'd2, 16'd1), "S3 R9 R6");
        // S4: jump on carry taken, stack slot B, SP pop
        poke(RG_CALL, 10'd1, 16'd0, 32'd9);
        run_step(mk(PC_JCARRY, SP_POP, ACC_FROM_ALU, 1'b0, 1'b0, 1'b1, RG_CALL, RG_LIT, 15'd0, 16'd0, 16'h0040), "S4 R7 R8");
        // S5: jump on carry not taken, SP pop wraps below zero, acc from global
        poke(RG_GLOB, 10'd0, 16'h0011, 32'h0155_A0F0);
        run_step(mk(PC_JCARRY, SP_POP, ACC_FROM_A, 1'b0, 1'b0, 1'b0, RG_LIT, RG_GLOB, 15'd0, 16'd0, 16'h0011), "S5 R7 R8");
        // S6: heap address from acc, indirect jump to acc[15:0], SP push wraps to zero
        poke(RG_HEAP, 10'h155, 16'hA0F0, 32'h1111_1111);
        poke(RG_FTAB, 10'd0, 16'd3, 32'h2222_2222);
        run_step(mk(PC_FROM_ACC, SP_PUSH, ACC_HOLD_ALT, 1'b0, 1'b0, 1'b1, RG_FTAB, RG_HEAP, 15'd0, 16'd3, 16'hA0F0), "S6 R4 R7");
        // S7: unconditional jump to the top of PC space
        run_step(mk(PC_JUMP, SP_HOLD_ALT, ACC_HOLD, 1'b0, 1'b0, 1'b0, RG_LIT, RG_LIT, 15'd0, 16'd0, 16'hFFFF), "S7 R7");
        // S8: PC falls through 0xFFFF, add with carry-out, carry written back
        poke(RG_LIT, 10'd0, 16'd1, 32'hFFFF_FFFF);
        poke(RG_LOCAL, 10'd3, 16'd9, 32'd1);
        run_step(mk(PC_NEXT, SP_HOLD, ACC_FROM_ALU, 1'b0, 1'b1, 1'b1, RG_LOCAL, RG_LIT, 15'd0, 16'd9, 16'd1), "S8 R7 R10");
        // S9: jump on carry held from S8, reading the word S8 wrote
        run_step(mk(PC_JCARRY, SP_HOLD, ACC_FROM_A, 1'b0, 1'b0, 1'b1, RG_LOCAL, RG_LOCAL, 15'd1, 16'd9, 16'd9), "S9 R7 R5");

        repeat (3) @(negedge clk);
        chk("R2 no pending steps", 64'(sb_q.size()), 64'd0);
        chk("R2 done idle", 64'(done), 64'd0);
        finish_run();
    end
endmodule